// File: doc/BRIEF.md
# Programmable CRC16/CRC32 Engine

This block is a memory-mapped checksum engine. A processor writes data words, half-words or single bytes into its data register. Each write folds exactly the written bytes into a running cyclic redundancy check. The polynomial is programmable and the width is either 16 or 32 bits. The running value can be read back at any time. An optional inversion is applied on that read path only.

Each computation starts from a seed. Software loads the seed through the data register while the seed-load control bit is set. A checksum that was read back earlier can later be loaded again as a seed, with the same polynomial and width. Work interrupted in this way continues exactly where it stopped. This lets several streams share one engine.

Data is processed most-significant bit first, with no reflection. Within one access the highest enabled byte lane goes first. Every write completes in the clock edge that accepts it.

Top module: `crc_periph`

## Requirements
- R1: After reset, reads at the data, polynomial and control offsets all return zero.
- R2: Word offset 0x00 is the data register, 0x04 the polynomial register and 0x08 the control register. The polynomial reads back as written. The control register keeps only bits 24 (width), 25 (seed load) and 26 (invert), and every other bit reads zero. Any other address, including one with nonzero low two bits, reads zero and writes nothing.
- R3: While control bit 25 is 1, a data write copies its enabled byte lanes into the checksum state without hashing them. Other lanes keep their value, and the result is masked to the selected width.
- R4: With control bit 24 = 1, the engine computes a 32-bit MSB-first CRC over the written bytes. The polynomial is given without its top term; for example, 0x04C11DB7 with seed 0xFFFFFFFF gives 0x0376E6E7 over the ASCII string "123456789".
- R5: With control bit 24 = 0, only the low 16 bits of the polynomial and state are used, and bits 31:16 of a data read are zero. For example, 0x1021 with seed 0 gives 0x31C3 over "123456789", and with seed 0xFFFF it gives 0x29B1.
- R6: Byte strobes bus_be[3:0] select lanes wdata[31:24]..wdata[7:0]. A data write advances the CRC by exactly the enabled bytes, lane 3 first and lane 0 last. A write with no lane enabled leaves the state unchanged.
- R7: With control bit 26 = 1, a data read returns the state with every bit of the selected width inverted. The stored state is not changed.
- R8: Loading a value read back earlier as the seed, with the same polynomial and width, gives the same final checksum as an uninterrupted stream.
- R9: Writes to the polynomial or control register never change the checksum state.
- R10: A data write is visible to a read issued in the next cycle. Cycles with bus_sel low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | LANES | Byte-lane write strobes |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the same cycle as a read access |

## Verification
The assertions assume the bus signals are held at known values whenever bus_sel is high. They also assume a read never occurs in the same cycle as a write, because one signal selects the direction. The bench always drives these signals on the falling clock edge and returns bus_sel to low between accesses. It idles at least one cycle with bus_we high and bus_sel low, so a stray write strobe can be shown to have no effect. Its seed loads use full or single-lane strobes, and it changes width only where the state was computed in the narrower mode, so the masking rules stay within the behaviour the requirements define.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;
    localparam int ADDR_W = 4;
    localparam int IDX_W  = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_POLY = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(2);

    localparam int BIT_WIDE = 24;
    localparam int BIT_SEED = 25;
    localparam int BIT_INV  = 26;

    typedef struct packed {
        logic [BUS_W-1:0] state;
        logic [BUS_W-1:0] poly;
        logic             wide;
        logic             seed_mode;
        logic             inv_out;
    } crc_regs_t;

    function automatic logic [BUS_W-1:0] width_mask(input logic wide);
        return wide ? {BUS_W{1'b1}} : {{(BUS_W/2){1'b0}}, {(BUS_W/2){1'b1}}};
    endfunction

    function automatic logic [BUS_W-1:0] merge_lanes(
        input logic [BUS_W-1:0] old_v,
        input logic [BUS_W-1:0] new_v,
        input logic [LANES-1:0] be
    );
        logic [BUS_W-1:0] r;
        r = old_v;
        for (int l = 0; l < LANES; l++) begin
            if (be[l]) r[8*l +: 8] = new_v[8*l +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
(
    input  logic [BUS_W-1:0] state_i,
    input  logic [7:0]       byte_i,
    input  logic [BUS_W-1:0] poly_i,
    input  logic             wide_i,
    input  logic             en_i,
    output logic [BUS_W-1:0] state_o
);

    logic [BUS_W-1:0] s;
    logic [BUS_W-1:0] m;
    logic             fb;

    always_comb begin
        m = width_mask(wide_i);
        s = state_i & m;
        fb = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            fb = (wide_i ? s[BUS_W-1] : s[BUS_W/2-1]) ^ byte_i[b];
            s  = {s[BUS_W-2:0], 1'b0};
            if (fb) s = s ^ poly_i;
            s  = s & m;
        end
        state_o = en_i ? s : state_i;
    end

endmodule

// File: rtl/crc_lane_chain.sv
module crc_lane_chain
    import crc_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [BUS_W-1:0]     state_i,
    input  logic [8*N_LANES-1:0] data_i,
    input  logic [N_LANES-1:0]   be_i,
    input  logic [BUS_W-1:0]     poly_i,
    input  logic                 wide_i,
    output logic [BUS_W-1:0]     state_o
);

    // link[N_LANES] enters the highest lane; link[0] leaves the lowest.
    logic [N_LANES:0][BUS_W-1:0] link;

    assign link[N_LANES] = state_i;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        crc_byte_step u_step (
            .state_i (link[g+1]),
            .byte_i  (data_i[8*g +: 8]),
            .poly_i  (poly_i),
            .wide_i  (wide_i),
            .en_i    (be_i[g]),
            .state_o (link[g])
        );
    end

    assign state_o = link[0];

endmodule

// File: rtl/crc_bus_decode.sv
module crc_bus_decode
    import crc_pkg::*;
(
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wr_data_o,
    output logic              wr_poly_o,
    output logic              wr_ctrl_o,
    output logic              rd_data_o,
    output logic              rd_poly_o,
    output logic              rd_ctrl_o
);

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             hit_data;
    logic             hit_poly;
    logic             hit_ctrl;

    always_comb begin
        aligned  = (addr_i[1:0] == 2'b00) && sel_i;
        idx      = addr_i[ADDR_W-1:2];
        hit_data = aligned && (idx == IDX_DATA);
        hit_poly = aligned && (idx == IDX_POLY);
        hit_ctrl = aligned && (idx == IDX_CTRL);
        wr_data_o = hit_data && we_i;
        wr_poly_o = hit_poly && we_i;
        wr_ctrl_o = hit_ctrl && we_i;
        rd_data_o = hit_data && !we_i;
        rd_poly_o = hit_poly && !we_i;
        rd_ctrl_o = hit_ctrl && !we_i;
    end

endmodule

// File: rtl/crc_periph.sv
module crc_periph
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    crc_regs_t r_d, r_q;

    logic wr_data, wr_poly, wr_ctrl;
    logic rd_data, rd_poly, rd_ctrl;
    logic [BUS_W-1:0] hashed;
    logic [BUS_W-1:0] mask_q;

    // Flat views of the registers for the bound checker.
    logic [BUS_W-1:0] state_q;
    logic [BUS_W-1:0] poly_q;
    logic             wide_q;
    logic             seed_q;
    logic             inv_q;

    assign state_q = r_q.state;
    assign poly_q  = r_q.poly;
    assign wide_q  = r_q.wide;
    assign seed_q  = r_q.seed_mode;
    assign inv_q   = r_q.inv_out;

    crc_bus_decode u_dec (
        .sel_i     (bus_sel),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wr_data_o (wr_data),
        .wr_poly_o (wr_poly),
        .wr_ctrl_o (wr_ctrl),
        .rd_data_o (rd_data),
        .rd_poly_o (rd_poly),
        .rd_ctrl_o (rd_ctrl)
    );

    crc_lane_chain #(.N_LANES(LANES)) u_chain (
        .state_i (r_q.state),
        .data_i  (bus_wdata),
        .be_i    (bus_be),
        .poly_i  (r_q.poly),
        .wide_i  (r_q.wide),
        .state_o (hashed)
    );

    always_comb begin
        r_d = r_q;
        if (wr_poly) begin
            r_d.poly = merge_lanes(r_q.poly, bus_wdata, bus_be);
        end
        if (wr_ctrl && bus_be[BIT_WIDE/8]) begin
            r_d.wide      = bus_wdata[BIT_WIDE];
            r_d.seed_mode = bus_wdata[BIT_SEED];
            r_d.inv_out   = bus_wdata[BIT_INV];
        end
        if (wr_data) begin
            if (r_q.seed_mode) begin
                r_d.state = merge_lanes(r_q.state, bus_wdata, bus_be) & width_mask(r_q.wide);
            end else begin
                r_d.state = hashed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mask_q    = width_mask(r_q.wide);
        bus_rdata = '0;
        if (rd_data) begin
            bus_rdata = (r_q.state & mask_q) ^ (r_q.inv_out ? mask_q : '0);
        end else if (rd_poly) begin
            bus_rdata = r_q.poly;
        end else if (rd_ctrl) begin
            bus_rdata[BIT_WIDE] = r_q.wide;
            bus_rdata[BIT_SEED] = r_q.seed_mode;
            bus_rdata[BIT_INV]  = r_q.inv_out;
        end
    end

endmodule

// File: rtl/crc_periph_chk.sv
module crc_periph_chk
    import crc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]  bus_be,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [BUS_W-1:0]  state_q,
    input logic [BUS_W-1:0]  poly_q,
    input logic              wide_q,
    input logic              seed_q,
    input logic              inv_q
);

    logic at_data, at_cfg;
    assign at_data = bus_sel && (bus_addr == ADDR_W'(0));
    assign at_cfg  = bus_sel && (bus_addr[1:0] == 2'b00) &&
                     ((bus_addr[ADDR_W-1:2] == IDX_POLY) || (bus_addr[ADDR_W-1:2] == IDX_CTRL));

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_data && bus_we && seed_q && wide_q && (bus_be == '1) |=> state_q == $past(bus_wdata));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_data && !bus_we && !wide_q |-> bus_rdata[BUS_W-1:BUS_W/2] == '0);

    // R6
    no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_data && bus_we && (bus_be == '0) |=> $stable(state_q));

    // R7
    invert_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_data && !bus_we && wide_q && inv_q |-> bus_rdata == ~state_q);

    // R9
    cfg_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_cfg && bus_we |=> $stable(state_q));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(state_q) && $stable(poly_q) && $stable(wide_q));

endmodule

bind crc_periph crc_periph_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .state_q   (state_q),
    .poly_q    (poly_q),
    .wide_q    (wide_q),
    .seed_q    (seed_q),
    .inv_q     (inv_q)
);

// File: tb/sim_crc_periph.sv
`timescale 1ns/1ps
module sim_crc_periph;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] C_WIDE = 32'h0100_0000;
    localparam logic [31:0] C_SEED = 32'h0200_0000;
    localparam logic [31:0] C_INV  = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_periph u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_byte(logic [31:0] s, logic [7:0] b, logic [31:0] p, bit wide);
        logic [31:0] m;
        m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        s = s & m;
        for (int i = 7; i >= 0; i--) begin
            if (((wide ? s[31] : s[15]) ^ b[i]) == 1'b1) s = ((s << 1) ^ p) & m;
            else s = (s << 1) & m;
        end
        return s;
    endfunction

    function automatic logic [31:0] m_write(logic [31:0] s, logic [31:0] d, logic [3:0] be,
                                            logic [31:0] p, bit wide);
        for (int l = 3; l >= 0; l--) if (be[l]) s = m_byte(s, d[8*l +: 8], p, wide);
        return s;
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rchk(string req, logic [3:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic seed(logic [31:0] ctrl, logic [31:0] sv);
        wr(4'h8, ctrl | C_SEED, 4'hF);
        wr(4'h0, sv, 4'hF);
        wr(4'h8, ctrl, 4'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp_s, d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rchk("R1 data", 4'h0, 32'h0);
        rchk("R1 poly", 4'h4, 32'h0);
        rchk("R1 ctrl", 4'h8, 32'h0);

        // R2: map and control bit storage
        wr(4'h4, 32'h04C1_1DB7, 4'hF);
        rchk("R2 poly readback", 4'h4, 32'h04C1_1DB7);
        wr(4'h8, 32'hFFFF_FFFF, 4'hF);
        rchk("R2 ctrl bits", 4'h8, 32'h0700_0000);
        rchk("R2 unmapped", 4'hC, 32'h0);
        wr(4'h5, 32'h1111_1111, 4'hF);
        rchk("R2 misaligned ignored", 4'h4, 32'h04C1_1DB7);

        // R4 + R6: 32-bit check value via word, word, byte
        seed(C_WIDE, 32'hFFFF_FFFF);
        wr(4'h0, 32'h3132_3334, 4'hF);
        wr(4'h0, 32'h3536_3738, 4'hF);
        wr(4'h0, 32'h0000_0039, 4'h1);
        rchk("R4 crc32 check", 4'h0, 32'h0376_E6E7);

        // R8: interrupt, store, reseed with junk, resume
        seed(C_WIDE, 32'hFFFF_FFFF);
        wr(4'h0, 32'h3132_3334, 4'hF);
        rd(4'h0, v);
        seed(C_WIDE, 32'hDEAD_BEEF);
        seed(C_WIDE, v);
        wr(4'h0, 32'h3536_3738, 4'hF);
        wr(4'h0, 32'h0039_0000, 4'h4);
        rchk("R8 resumed checksum", 4'h0, 32'h0376_E6E7);

        // R3: partial-lane seed load
        seed(C_WIDE, 32'h1122_3344);
        wr(4'h8, C_WIDE | C_SEED, 4'hF);
        wr(4'h0, 32'h0055_0000, 4'h4);
        wr(4'h8, C_WIDE, 4'hF);
        rchk("R3 lane seed", 4'h0, 32'h1155_3344);

        // R7: invert on 32-bit read, state unchanged
        wr(4'h8, C_WIDE | C_INV, 4'hF);
        rchk("R7 inverted wide", 4'h0, 32'hEEAA_CCBB);
        wr(4'h8, C_WIDE, 4'hF);
        rchk("R7 state kept", 4'h0, 32'h1155_3344);

        // R6: sweep every strobe pattern, 32-bit mode
        seed(C_WIDE, 32'hFFFF_FFFF);
        exp_s = 32'hFFFF_FFFF;
        for (int be = 0; be < 16; be++) begin
            for (int k = 0; k < 8; k++) begin
                d = $urandom;
                wr(4'h0, d, 4'(be));
                exp_s = m_write(exp_s, d, 4'(be), 32'h04C1_1DB7, 1'b1);
                rchk("R6 strobe sweep", 4'h0, exp_s);
            end
        end

        // R5: 16-bit check values, halfword then bytes
        wr(4'h4, 32'hABCD_1021, 4'hF);
        seed(32'h0, 32'h0);
        wr(4'h0, 32'h0000_3132, 4'h3);
        wr(4'h0, 32'h3334_0000, 4'hC);
        wr(4'h0, 32'h3536_3738, 4'hF);
        wr(4'h0, 32'h3900_0000, 4'h8);
        rchk("R5 crc16 seed0", 4'h0, 32'h0000_31C3);

        // R9: width and polynomial change keep the state
        wr(4'h4, 32'h04C1_1DB7, 4'hF);
        wr(4'h8, C_WIDE, 4'hF);
        rchk("R9 state kept", 4'h0, 32'h0000_31C3);

        // R5 + R6: all 256 single-byte values across lanes, 16-bit mode
        wr(4'h4, 32'h0000_1021, 4'hF);
        seed(32'h0, 32'h0000_FFFF);
        exp_s = 32'h0000_FFFF;
        for (int i = 0; i < 256; i++) begin
            d = {4{8'(i)}};
            wr(4'h0, d, 4'(1 << (i % 4)));
            exp_s = m_byte(exp_s, 8'(i), 32'h1021, 1'b0);
            rchk("R6 byte sweep", 4'h0, exp_s);
        end

        // R5: second 16-bit check value, R7 narrow invert
        seed(32'h0, 32'hFFFF_FFFF);
        rchk("R5 seed masked", 4'h0, 32'h0000_FFFF);
        wr(4'h0, 32'h3132_3334, 4'hF);
        wr(4'h0, 32'h3536_3738, 4'hF);
        wr(4'h0, 32'h0000_0039, 4'h1);
        rchk("R5 crc16 seedFFFF", 4'h0, 32'h0000_29B1);
        wr(4'h8, C_INV, 4'hF);
        rchk("R7 inverted narrow", 4'h0, 32'h0000_D64E);
        wr(4'h8, 32'h0, 4'hF);

        // R10: strobes with bus_sel low do nothing
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h1234_5678; bus_be = 4'hF;
        repeat (3) @(negedge clk);
        bus_addr = 4'h4;
        repeat (2) @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
        rchk("R10 idle data", 4'h0, 32'h0000_29B1);
        rchk("R10 idle poly", 4'h4, 32'h0000_1021);

        // R10: read right after a write sees the update
        wr(4'h0, 32'h0000_0000, 4'h1);
        rchk("R10 next-cycle read", 4'h0, m_byte(32'h29B1, 8'h00, 32'h1021, 1'b0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule